// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small register-register processor core. One operand pair, an incoming carry, an incoming zero flag and an operation code go in. Out of the same cycle come an 8-bit result, six status flag values and a write mask that tells the flag register which of the six the operation is allowed to update. Flags outside the mask keep their old value in the flag register, so increment, decrement and the logical operations leave carry alone, and the nibble swap leaves every flag alone.

A separate two-cycle path adds or subtracts a small unsigned immediate to or from a 16-bit register pair. In the first cycle it processes the low byte. In the second cycle it processes the high byte, using the carry or borrow from the first. Operand fetch, write-back and multiplication belong to neighbouring blocks.

Flag bit positions on every flag bus: C=0, Z=1, N=2, V=3, S=4, H=5.

Top module: `alu8_core`

## Requirements
- R1: Opcodes 0 add, 1 add with carry_i, 2 subtract, 3 subtract with carry_i as borrow. The result is the low 8 bits. C is the carry out (add) or the borrow (subtract). H is the carry out of bit 3 (add) or the borrow into bit 4 (subtract). V is two's complement overflow. N is bit 7 and Z means the result is zero. The mask is 0b101111 (H, V, N, Z, C).
- R2: For opcode 3, Z is 1 only when the result is zero and zero_i is 1, so that multi-byte compares chain.
- R3: Opcode 8 gives 0x00 minus a_i, with the flags and mask of R1. Opcode 7 gives 0xFF minus a_i, with C=1, V=0 and mask 0b001111.
- R4: Opcodes 4 AND, 5 OR and 6 XOR of a_i and b_i give V=0 and mask 0b001110 (V, N, Z). Carry is not written.
- R5: Opcodes 9 increment and 10 decrement of a_i use mask 0b001110. V is 1 exactly when the result is 0x80 (increment) or 0x7F (decrement).
- R6: Opcode 16 exchanges bits 7:4 with bits 3:0 of a_i, and the mask is 0.
- R7: Opcodes 11 shift left, 12 logical shift right, 13 rotate left through carry_i, 14 rotate right through carry_i and 15 arithmetic shift right all work on a_i. C is the bit shifted out and V is N XOR C. Arithmetic shift right keeps bit 7. The mask is 0b001111.
- R8: The S flag output always equals N XOR V.
- R9: If word_start_i is high while the word path is idle, word_busy_o is high for the next cycle. In the cycle after that, word_done_o pulses for one cycle. At that point word_res_o holds word_pair_i plus (or, with word_sub_i, minus) the zero-extended word_imm_i, modulo 2^16. word_flags_o then holds Z, C (carry or borrow), N (bit 15), V and S for the 16-bit operation.
- R10: word_start_i is ignored while word_busy_o is high.
- R11: While rst_ni is low, word_busy_o, word_done_o and word_res_o are all 0.
- R12: Opcodes 17 to 31 give a result of 0 and a mask of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock for the word path |
| rst_ni | input | 1 | asynchronous reset, active low |
| op_i | input | 5 | operation code |
| a_i | input | 8 | first operand |
| b_i | input | 8 | second operand or immediate |
| carry_i | input | 1 | current carry flag |
| zero_i | input | 1 | current zero flag |
| res_o | output | 8 | result |
| flags_o | output | 6 | computed flag values |
| fmask_o | output | 6 | flag write mask |
| word_start_i | input | 1 | start word operation |
| word_sub_i | input | 1 | 1 selects subtract |
| word_pair_i | input | 16 | register pair value |
| word_imm_i | input | 6 | unsigned immediate |
| word_busy_o | output | 1 | word path in high-byte cycle |
| word_done_o | output | 1 | word result valid pulse |
| word_res_o | output | 16 | word result |
| word_flags_o | output | 6 | word flag values |

## Verification
The bench aims at the half-carry boundary (0x0F+1), the signed overflow edges (0x7F+1, 0x80-1) and the wrap cases for increment and decrement. A design with H or V computed at the wrong bit would set these flags on the wrong inputs. It also chains subtract-with-carry with zero_i both low and high: a design that ignores zero_i reports equality when a higher byte already differed. The word path is tested across the low-byte carry (0x00FF+1), across a borrow through zero and at 16-bit overflow. A design that drops the inter-byte carry returns 0x0000 or 0x00FF instead of the correct value. A second start during the busy cycle must not produce a second done pulse.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 6;
  localparam int F_C = 0;
  localparam int F_Z = 1;
  localparam int F_N = 2;
  localparam int F_V = 3;
  localparam int F_S = 4;
  localparam int F_H = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB  = 5'd2,  OP_SBC  = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR  = 5'd6,  OP_COM  = 5'd7,
    OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC  = 5'd10, OP_LSL  = 5'd11,
    OP_LSR  = 5'd12, OP_ROL  = 5'd13, OP_ROR  = 5'd14, OP_ASR  = 5'd15,
    OP_SWAP = 5'd16
  } op_e;

  localparam logic [FLAG_W-1:0] M_ARITH = 6'b101111;
  localparam logic [FLAG_W-1:0] M_LOGIC = 6'b001110;
  localparam logic [FLAG_W-1:0] M_SHIFT = 6'b001111;
  localparam logic [FLAG_W-1:0] M_WORD  = 6'b011111;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
  parameter int DW     = 8,
  parameter int HALF_W = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  input  logic          sub_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          h_o,
  output logic          v_o
);
  logic [DW-1:0]   b_eff;
  logic            cin_eff;
  logic [DW:0]     sum;
  logic [HALF_W:0] nib;

  // subtract as a + ~b + ~borrow
  assign b_eff   = sub_i ? ~b_i : b_i;
  assign cin_eff = sub_i ? ~cin_i : cin_i;
  assign sum     = {1'b0, a_i} + {1'b0, b_eff} + {{DW{1'b0}}, cin_eff};
  assign nib     = {1'b0, a_i[HALF_W-1:0]} + {1'b0, b_eff[HALF_W-1:0]}
                 + {{HALF_W{1'b0}}, cin_eff};

  assign res_o = sum[DW-1:0];
  assign c_o   = sum[DW] ^ sub_i;
  assign h_o   = nib[HALF_W] ^ sub_i;
  assign v_o   = (a_i[DW-1] == b_eff[DW-1]) && (sum[DW-1] != a_i[DW-1]);
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int DW = 8
) (
  input  op_e           op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          v_o
);
  localparam int HW = DW / 2;

  always_comb begin
    res_o = '0;
    c_o   = 1'b0;
    unique case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  begin res_o = ~a_i; c_o = 1'b1; end
      OP_LSL:  begin res_o = {a_i[DW-2:0], 1'b0};       c_o = a_i[DW-1]; end
      OP_LSR:  begin res_o = {1'b0, a_i[DW-1:1]};       c_o = a_i[0];    end
      OP_ROL:  begin res_o = {a_i[DW-2:0], cin_i};      c_o = a_i[DW-1]; end
      OP_ROR:  begin res_o = {cin_i, a_i[DW-1:1]};      c_o = a_i[0];    end
      OP_ASR:  begin res_o = {a_i[DW-1], a_i[DW-1:1]};  c_o = a_i[0];    end
      OP_SWAP: res_o = {a_i[HW-1:0], a_i[DW-1:HW]};
      default: ;
    endcase
    // shifts: V = N ^ C; logic and complement: V = 0
    v_o = (op_i inside {OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR}) ? (res_o[DW-1] ^ c_o) : 1'b0;
  end
endmodule

// File: rtl/alu8_word.sv
module alu8_word
  import alu8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int IMM_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sub_i,
  input  logic [2*DW-1:0]   pair_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [2*DW-1:0]   res_o,
  output logic [FLAG_W-1:0] flags_o
);
  localparam int PAD = DW + 1 - IMM_W;

  logic              busy_q, done_q, cy_q, sub_q;
  logic [DW-1:0]     lo_q, hi_q, hi_res;
  logic [DW:0]       lo_sum, imm_ext;
  logic [2*DW-1:0]   res_q;
  logic [FLAG_W-1:0] flags_q, flags_d;

  assign imm_ext = {{PAD{1'b0}}, imm_i};
  assign lo_sum  = sub_i ? ({1'b0, pair_i[DW-1:0]} - imm_ext)
                         : ({1'b0, pair_i[DW-1:0]} + imm_ext);
  assign hi_res  = sub_q ? (hi_q - {{(DW-1){1'b0}}, cy_q})
                         : (hi_q + {{(DW-1){1'b0}}, cy_q});

  always_comb begin
    flags_d      = '0;
    flags_d[F_Z] = ({hi_res, lo_q} == '0);
    flags_d[F_N] = hi_res[DW-1];
    flags_d[F_V] = sub_q ? (hi_q[DW-1] & ~hi_res[DW-1]) : (~hi_q[DW-1] & hi_res[DW-1]);
    flags_d[F_C] = sub_q ? (~hi_q[DW-1] & hi_res[DW-1]) : (hi_q[DW-1] & ~hi_res[DW-1]);
    flags_d[F_S] = flags_d[F_N] ^ flags_d[F_V];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cy_q    <= 1'b0;
      sub_q   <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      done_q <= busy_q;
      if (busy_q) begin
        busy_q  <= 1'b0;
        res_q   <= {hi_res, lo_q};
        flags_q <= flags_d;
      end else if (start_i) begin
        busy_q <= 1'b1;
        lo_q   <= lo_sum[DW-1:0];
        cy_q   <= lo_sum[DW];
        hi_q   <= pair_i[2*DW-1:DW];
        sub_q  <= sub_i;
      end
    end
  end

  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign res_o   = res_q;
  assign flags_o = flags_q;

  p_word_done_after_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
  p_word_busy_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);
  p_word_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DW     = 8,
  parameter int HALF_W = 4,
  parameter int IMM_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic              carry_i,
  input  logic              zero_i,
  output logic [DW-1:0]     res_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] fmask_o,
  input  logic              word_start_i,
  input  logic              word_sub_i,
  input  logic [2*DW-1:0]   word_pair_i,
  input  logic [IMM_W-1:0]  word_imm_i,
  output logic              word_busy_o,
  output logic              word_done_o,
  output logic [2*DW-1:0]   word_res_o,
  output logic [FLAG_W-1:0] word_flags_o
);
  op_e           op;
  logic [DW-1:0] ar_a, ar_b, ar_res, bt_res;
  logic          ar_cin, ar_sub, ar_c, ar_h, ar_v, bt_c, bt_v;
  logic          use_arith;
  logic          f_c, f_v, f_h, f_n, f_z;

  assign op = op_e'(op_i);

  // operand steering into the shared adder
  always_comb begin
    ar_a      = a_i;
    ar_b      = b_i;
    ar_cin    = 1'b0;
    ar_sub    = 1'b0;
    use_arith = 1'b1;
    unique case (op)
      OP_ADD: ;
      OP_ADC: ar_cin = carry_i;
      OP_SUB: ar_sub = 1'b1;
      OP_SBC: begin ar_sub = 1'b1; ar_cin = carry_i; end
      OP_NEG: begin ar_a = '0; ar_b = a_i; ar_sub = 1'b1; end
      OP_INC: ar_b = {{(DW-1){1'b0}}, 1'b1};
      OP_DEC: begin ar_b = {{(DW-1){1'b0}}, 1'b1}; ar_sub = 1'b1; end
      default: use_arith = 1'b0;
    endcase
  end

  alu8_arith #(.DW(DW), .HALF_W(HALF_W)) u_arith (
    .a_i(ar_a), .b_i(ar_b), .cin_i(ar_cin), .sub_i(ar_sub),
    .res_o(ar_res), .c_o(ar_c), .h_o(ar_h), .v_o(ar_v)
  );

  alu8_bitops #(.DW(DW)) u_bitops (
    .op_i(op), .a_i(a_i), .b_i(b_i), .cin_i(carry_i),
    .res_o(bt_res), .c_o(bt_c), .v_o(bt_v)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG:    fmask_o = M_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC:     fmask_o = M_LOGIC;
      OP_COM, OP_LSL, OP_LSR, OP_ROL, OP_ROR,
      OP_ASR:                                    fmask_o = M_SHIFT;
      default:                                   fmask_o = '0;
    endcase
  end

  assign res_o = use_arith ? ar_res : bt_res;
  assign f_c   = use_arith ? ar_c : bt_c;
  assign f_v   = use_arith ? ar_v : bt_v;
  assign f_h   = use_arith & ar_h;
  assign f_n   = res_o[DW-1];
  // chained compare: zero only survives if the higher bytes were equal
  assign f_z   = (res_o == '0) & ((op != OP_SBC) | zero_i);

  always_comb begin
    flags_o      = '0;
    flags_o[F_C] = f_c;
    flags_o[F_Z] = f_z;
    flags_o[F_N] = f_n;
    flags_o[F_V] = f_v;
    flags_o[F_S] = f_n ^ f_v;
    flags_o[F_H] = f_h;
  end

  alu8_word #(.DW(DW), .IMM_W(IMM_W)) u_word (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(word_start_i), .sub_i(word_sub_i),
    .pair_i(word_pair_i), .imm_i(word_imm_i), .busy_o(word_busy_o),
    .done_o(word_done_o), .res_o(word_res_o), .flags_o(word_flags_o)
  );

  p_swap_no_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SWAP) |-> (fmask_o == '0));
  p_incdec_keep_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op inside {OP_INC, OP_DEC}) |-> !fmask_o[F_C]);
  p_logic_v_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op inside {OP_AND, OP_OR, OP_XOR}) |-> !flags_o[F_V]);
  p_asr_keeps_sign_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_ASR) |-> (res_o[DW-1] == a_i[DW-1]));
  p_sbc_zero_chain_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SBC && !zero_i) |-> !flags_o[F_Z]);
  p_unused_op_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i > 5'd16) |-> (fmask_o == '0 && res_o == '0));
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  op = '0;
  logic [7:0]  a = '0, b = '0;
  logic        cin = 1'b0, zin = 1'b0;
  logic [7:0]  res;
  logic [5:0]  flags, fmask;
  logic        wstart = 1'b0, wsub = 1'b0;
  logic [15:0] wpair = '0;
  logic [5:0]  wimm = '0;
  logic        wbusy, wdone;
  logic [15:0] wres;
  logic [5:0]  wflags;

  int checks = 0;
  int bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  alu8_core dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .a_i(a), .b_i(b), .carry_i(cin),
    .zero_i(zin), .res_o(res), .flags_o(flags), .fmask_o(fmask),
    .word_start_i(wstart), .word_sub_i(wsub), .word_pair_i(wpair),
    .word_imm_i(wimm), .word_busy_o(wbusy), .word_done_o(wdone),
    .word_res_o(wres), .word_flags_o(wflags)
  );

  function automatic string req_of(int o);
    if (o <= 3) return "R1";
    if (o == 7 || o == 8) return "R3";
    if (o >= 4 && o <= 6) return "R4";
    if (o == 9 || o == 10) return "R5";
    if (o == 16) return "R6";
    if (o >= 11 && o <= 15) return "R7";
    return "R12";
  endfunction

  task automatic check8(input int o, input int av, input int bv, input bit c, input bit z);
    int r, cf, hf, vf, sr, m;
    logic [5:0] ef;
    int sa, sb;
    op = o[4:0]; a = av[7:0]; b = bv[7:0]; cin = c; zin = z;
    #1;
    sa = (av > 127) ? av - 256 : av;
    sb = (bv > 127) ? bv - 256 : bv;
    r = 0; cf = 0; hf = 0; vf = 0; m = 0;
    case (o)
      0, 1: begin
        r = av + bv + ((o == 1) ? int'(c) : 0);
        hf = ((av % 16) + (bv % 16) + ((o == 1) ? int'(c) : 0)) > 15;
        sr = sa + sb + ((o == 1) ? int'(c) : 0);
        cf = r > 255; vf = (sr > 127 || sr < -128); m = 6'b101111;
      end
      2, 3: begin
        r = av - bv - ((o == 3) ? int'(c) : 0);
        hf = ((av % 16) - (bv % 16) - ((o == 3) ? int'(c) : 0)) < 0;
        sr = sa - sb - ((o == 3) ? int'(c) : 0);
        cf = r < 0; vf = (sr > 127 || sr < -128); m = 6'b101111;
      end
      8: begin
        r = 0 - av; hf = (av % 16) != 0; cf = av != 0; vf = (av == 128); m = 6'b101111;
      end
      7: begin r = 255 - av; cf = 1; m = 6'b001111; end
      4: begin r = av & bv; m = 6'b001110; end
      5: begin r = av | bv; m = 6'b001110; end
      6: begin r = av ^ bv; m = 6'b001110; end
      9:  begin r = av + 1; vf = ((r & 255) == 128); m = 6'b001110; end
      10: begin r = av - 1; vf = ((r & 255) == 127); m = 6'b001110; end
      11: begin r = av * 2; cf = av / 128; m = 6'b001111; end
      12: begin r = av / 2; cf = av % 2; m = 6'b001111; end
      13: begin r = av * 2 + int'(c); cf = av / 128; m = 6'b001111; end
      14: begin r = av / 2 + 128 * int'(c); cf = av % 2; m = 6'b001111; end
      15: begin r = av / 2 + (av / 128) * 128; cf = av % 2; m = 6'b001111; end
      16: begin r = (av % 16) * 16 + av / 16; m = 0; end
      default: begin r = 0; m = 0; end
    endcase
    r = r & 255;
    if (o >= 11 && o <= 15) vf = (r / 128) ^ cf;
    ef = '0;
    ef[0] = cf[0];
    ef[1] = (r == 0) && (o != 3 || z);
    ef[2] = r[7];
    ef[3] = vf[0];
    ef[4] = r[7] ^ vf[0];
    ef[5] = hf[0];
    checks++;
    if (res !== r[7:0] || fmask !== m[5:0] || (flags & m[5:0]) !== (ef & m[5:0]) ||
        (m[2] && flags[4] !== ef[4])) begin
      bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h c=%0b z=%0b: res=%02h flags=%06b mask=%06b expected res=%02h flags=%06b mask=%06b (S is %s)",
               req_of(o), o, av, bv, c, z, res, flags, fmask, r[7:0], ef, m[5:0], "R8");
    end
  endtask

  task automatic fail_w(input string rq, input string what, input int act, input int exp);
    bad++;
    $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
  endtask

  task automatic word_op(input bit sub, input int pair, input int imm, input bit try_again);
    int full, r, sf, sr;
    logic [5:0] ef;
    full = pair;
    r  = sub ? full - imm : full + imm;
    sf = (full > 32767) ? full - 65536 : full;
    sr = sub ? sf - imm : sf + imm;
    ef = '0;
    ef[0] = (r < 0 || r > 65535);
    r = r & 65535;
    ef[1] = (r == 0);
    ef[2] = r[15];
    ef[3] = (sr > 32767 || sr < -32768);
    ef[4] = ef[2] ^ ef[3];
    wsub = sub; wpair = pair[15:0]; wimm = imm[5:0]; wstart = 1'b1;
    @(negedge clk);
    if (try_again) begin
      wpair = 16'h1234; wimm = 6'd5; wsub = 1'b0;
    end else wstart = 1'b0;
    checks++;
    if (wbusy !== 1'b1 || wdone !== 1'b0) fail_w("R9", "busy/done in cycle 1", {wbusy, wdone}, 2);
    @(negedge clk);
    wstart = 1'b0;
    checks++;
    if (wdone !== 1'b1 || wbusy !== 1'b0) fail_w("R9", "busy/done in cycle 2", {wbusy, wdone}, 1);
    checks++;
    if (wres !== r[15:0]) fail_w("R9", "word result", wres, r);
    checks++;
    if ((wflags & 6'b011111) !== ef) fail_w("R9", "word flags", wflags, ef);
    @(negedge clk);
    checks++;
    if (wdone !== 1'b0 || wbusy !== 1'b0)
      fail_w(try_again ? "R10" : "R9", "idle after done", {wbusy, wdone}, 0);
    checks++;
    if (try_again && wres !== r[15:0]) fail_w("R10", "result kept", wres, r);
  endtask

  initial begin
    #(CLK_PER * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    checks++;
    if (wbusy !== 0 || wdone !== 0 || wres !== 0) fail_w("R11", "reset state", {wbusy, wdone, wres}, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 boundaries
    check8(0, 8'h0F, 8'h01, 0, 0);
    check8(0, 8'h7F, 8'h01, 0, 0);
    check8(0, 8'hFF, 8'h01, 0, 0);
    check8(1, 8'hFE, 8'h01, 1, 0);
    check8(2, 8'h80, 8'h01, 0, 0);
    check8(2, 8'h10, 8'h01, 0, 0);
    check8(3, 8'h00, 8'h00, 1, 1);
    // R2 zero chaining
    check8(3, 8'h42, 8'h42, 0, 0);
    check8(3, 8'h42, 8'h42, 0, 1);
    // R3
    check8(8, 8'h00, 0, 0, 0);
    check8(8, 8'h80, 0, 0, 0);
    check8(7, 8'h5A, 0, 0, 0);
    // R4
    check8(4, 8'hF0, 8'h0F, 1, 0);
    check8(6, 8'hFF, 8'h7F, 0, 0);
    // R5
    check8(9, 8'h7F, 0, 1, 0);
    check8(9, 8'hFF, 0, 0, 0);
    check8(10, 8'h80, 0, 0, 0);
    check8(10, 8'h00, 0, 1, 0);
    // R6
    check8(16, 8'hA5, 0, 1, 1);
    // R7
    check8(15, 8'h81, 0, 0, 0);
    check8(13, 8'h80, 0, 1, 0);
    check8(14, 8'h01, 0, 1, 0);
    check8(12, 8'h01, 0, 0, 0);
    // R12
    check8(20, 8'h33, 8'h44, 1, 1);

    // random sweep, one comparison per clock
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      check8($urandom_range(0, 31), $urandom_range(0, 255), $urandom_range(0, 255),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    // R9 word path
    @(negedge clk);
    word_op(0, 16'h00FF, 1, 0);
    word_op(1, 16'h0000, 1, 0);
    word_op(0, 16'h7FFF, 1, 0);
    word_op(1, 16'h0001, 1, 0);
    word_op(1, 16'h8000, 63, 0);
    word_op(0, 16'hFFC1, 63, 0);
    // R10 second start while busy
    word_op(0, 16'h0102, 7, 1);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule